// File: doc/BRIEF.md
# Up-Counting Event Timer with Output Pin

The block is a general-purpose up-counter. Software sets it up through a small word-addressed register port, and it signals its events on three lines. The counter advances either on every functional clock or once per power-of-two number of clocks. When it passes its all-ones value it either reloads from a load register and keeps going, or clears to zero and stops. An optional compare register raises a match event when the count reaches it.

Overflow and match events feed three consumers. The first is an interrupt status register whose bits latch only when enabled, and which software clears by writing ones. The second is a separately enabled one-cycle wakeup pulse. The third is a single output pin. The pin can pulse or toggle on overflow alone, or on both overflow and match. When no events drive it, it rests at a programmable level.

Register word addresses: 0 revision (reads 0x21), 1 system configuration (bit 1 soft reset), 2 status, 3 interrupt enable, 4 wakeup enable, 5 control, 6 count, 7 reload value, 8 fire (reload strobe, reads all ones), 9 pending writes (reads 0), 10 compare value, 11 sync mode (bit 2 posted flag, bit 1 soft reset). Reads are combinational from `bus_addr`. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, the status, `irq`, `wake` and `tmr_out` are 0. Address 0 reads 0x21, address 8 reads 0xFFFFFFFF, address 9 reads 0 and address 11 reads 4.
- R2: While control bit 0 (start) is set and the prescaler is off, the count rises by one on every clock. While start is clear, the count holds.
- R3: With control bit 5 set, the count rises once every 2^(P+1) clocks, where P is control bits 4:2. Counting begins with a full period after the control write.
- R4: On a counting step from 0xFFFFFFFF with control bit 1 (auto-reload) set, the count becomes the reload value and counting continues.
- R5: On a counting step from 0xFFFFFFFF with auto-reload clear, the count becomes 0 and control bit 0 clears.
- R6: With control bit 6 set, a match event occurs on each counting step whose new count equals the compare value. With bit 6 clear, no match event occurs.
- R7: Status bit 0 (match) and status bit 1 (overflow) set one clock after their event, and only when the same bit of the interrupt enable is set. `irq` is high while any status bit is set. Writing a 1 to a status bit clears it.
- R8: `wake` is a one-clock pulse, one clock after each event whose bit is set in the wakeup enable register, whatever the interrupt enable holds.
- R9: Control bits 11:10 select the trigger mode: 0 means no events and the pin follows control bit 7 (default level); 1 means overflow only; 2 means overflow and match; 3 means no events. The pin updates one clock after the event.
- R10: With control bit 12 set, each selected event inverts the pin. With it clear, the pin shows the default level, inverted for one clock per event.
- R11: While control bit 14 (pin is input) is set, `tmr_out` does not change.
- R12: A write to address 6 sets the count. Any write to address 8 loads the count from the reload value.
- R13: Writing bit 1 set to address 1 or address 11 returns every register, the count and the pin to 0, except the posted flag, which returns to 1.
- R14: The control register reads back bits 14:0 as written. The system configuration register keeps only the bits in mask 0x33D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, high while any status bit is set |
| wake | output | 1 | One-clock wakeup pulse |
| tmr_out | output | 1 | Event output pin |

## Verification
The count changes on the first edge after the control write when the prescaler is off. With the prescaler on, the first change comes 2^(P+1) edges after that write. The event strobes follow the step that caused them by one clock. The status bits, `irq`, `wake` and the pin follow the strobes by one more clock. So the bench drives each write at a falling edge and lets one rising edge apply it. It then counts whole rising edges from that write and samples at the falling edge where the result is due. It also samples one edge earlier, to show that `irq` and the pin have not yet moved. The pin sweep steps a behavioural model edge by edge from a fixed event schedule: overflow every fourth step, match one step after each reload. It compares `tmr_out` at every falling edge for all trigger modes, pin styles, default levels and directions.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_ID      = 4'd0,
        A_SYSCFG  = 4'd1,
        A_STATUS  = 4'd2,
        A_INT_EN  = 4'd3,
        A_WAKE_EN = 4'd4,
        A_CTRL    = 4'd5,
        A_COUNT   = 4'd6,
        A_RELOAD  = 4'd7,
        A_FIRE    = 4'd8,
        A_PEND    = 4'd9,
        A_MATCH   = 4'd10,
        A_SYNC    = 4'd11
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRG_NONE = 2'd0,
        TRG_OVF  = 2'd1,
        TRG_BOTH = 2'd2,
        TRG_RSVD = 2'd3
    } trig_e;

    // Packed most-significant field first: the positions are the software view.
    typedef struct packed {
        logic       pin_in;    // 14
        logic       cap_sel2;  // 13 (stored only)
        logic       toggle;    // 12
        trig_e      trig;      // 11:10
        logic [1:0] cap_mode;  // 9:8 (stored only)
        logic       dflt;      // 7
        logic       cmp_en;    // 6
        logic       pre_en;    // 5
        logic [2:0] ptv;       // 4:2
        logic       auto_rl;   // 1
        logic       start;     // 0
    } ctrl_t;

    localparam int unsigned EVT_N   = 3;   // top slot is the capture event, never raised
    localparam int unsigned EVT_MAT = 0;
    localparam int unsigned EVT_OVF = 1;

    localparam int unsigned CFG_W    = 10;
    localparam logic [CFG_W-1:0] CFG_MASK = 10'h33D;
    localparam logic [7:0]       REV_ID   = 8'h21;

endpackage

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale #(
    parameter int unsigned PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    localparam int unsigned DIV_W = 1 << PTV_W;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W:0]   period;
    logic [DIV_W-1:0] limit;

    always_comb begin
        period = (DIV_W+1)'(1) << (int'(ptv) + 1);
        limit  = DIV_W'(period - (DIV_W+1)'(1));
        tick   = run && (!pre_en || (div_q == limit));
        if (clr || !run || !pre_en || tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             set_wr,
    input  logic [CNT_W-1:0] set_val,
    input  logic             fire,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             mat_evt,
    output logic             stop_req
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             mat;
    } cnt_state_t;

    cnt_state_t c_d, c_q;
    logic       at_top;

    always_comb begin
        at_top   = &c_q.count;
        stop_req = tick && at_top && !auto_rl && !set_wr && !fire;
        c_d      = c_q;
        c_d.ovf  = 1'b0;
        c_d.mat  = 1'b0;
        if (set_wr) begin
            c_d.count = set_val;
        end else if (fire) begin
            c_d.count = load_val;
        end else if (tick) begin
            if (at_top) begin
                c_d.ovf   = 1'b1;
                c_d.count = auto_rl ? load_val : '0;
            end else begin
                c_d.count = c_q.count + CNT_W'(1);
            end
            c_d.mat = cmp_en && (c_d.count == match_val);
        end
        if (clr) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count   = c_q.count;
    assign ovf_evt = c_q.ovf;
    assign mat_evt = c_q.mat;
endmodule

// File: rtl/evt_timer_pin.sv
module evt_timer_pin
    import evt_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  trig_e trig,
    input  logic  toggle,
    input  logic  dflt,
    input  logic  pin_in,
    input  logic  ovf_evt,
    input  logic  mat_evt,
    output logic  pin
);
    logic pin_d, pin_q;
    logic hit;

    always_comb begin
        hit = (((trig == TRG_OVF) || (trig == TRG_BOTH)) && ovf_evt) ||
              ((trig == TRG_BOTH) && mat_evt);
        pin_d = pin_q;
        if (clr) begin
            pin_d = 1'b0;
        end else if (!pin_in) begin
            if (trig == TRG_NONE) begin
                pin_d = dflt;
            end else if (toggle) begin
                if (hit) pin_d = ~pin_q;
            end else begin
                pin_d = dflt ^ hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin = pin_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     count,
    input  logic              ovf_evt,
    input  logic              mat_evt,
    input  logic              stop_req,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     load_val,
    output logic [DW-1:0]     match_val,
    output logic              irq,
    output logic              wake,
    output logic              sreset,
    output logic              cnt_wr,
    output logic              fire,
    output logic              ctrl_wr
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             posted;
        logic [EVT_N-1:0] status;
        logic [EVT_N-1:0] int_en;
        logic [EVT_N-1:0] wake_en;
        ctrl_t            ctrl;
        logic [DW-1:0]    load;
        logic [DW-1:0]    match;
        logic             wake;
    } regs_t;

    localparam regs_t REGS_RST = '{posted: 1'b1, default: '0};

    regs_t            r_d, r_q;
    logic [EVT_N-1:0] ev;

    assign sreset  = bus_wr && bus_wdata[1] &&
                     ((bus_addr == A_SYSCFG) || (bus_addr == A_SYNC));
    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign fire    = bus_wr && (bus_addr == A_FIRE);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    always_comb begin
        ev          = '0;
        ev[EVT_MAT] = mat_evt;
        ev[EVT_OVF] = ovf_evt;
        r_d         = r_q;
        r_d.wake    = |(ev & r_q.wake_en);
        if (stop_req) r_d.ctrl.start = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                A_SYSCFG:  r_d.cfg     = bus_wdata[CFG_W-1:0] & CFG_MASK;
                A_STATUS:  r_d.status  = r_q.status & ~bus_wdata[EVT_N-1:0];
                A_INT_EN:  r_d.int_en  = bus_wdata[EVT_N-1:0];
                A_WAKE_EN: r_d.wake_en = bus_wdata[EVT_N-1:0];
                A_CTRL:    r_d.ctrl    = ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
                A_RELOAD:  r_d.load    = bus_wdata;
                A_MATCH:   r_d.match   = bus_wdata;
                A_SYNC:    r_d.posted  = bus_wdata[2];
                default:   ;
            endcase
        end
        r_d.status = r_d.status | (ev & r_q.int_en);
        if (sreset) begin
            r_d = REGS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            A_ID:      bus_rdata = DW'(REV_ID);
            A_SYSCFG:  bus_rdata = DW'(r_q.cfg);
            A_STATUS:  bus_rdata = DW'(r_q.status);
            A_INT_EN:  bus_rdata = DW'(r_q.int_en);
            A_WAKE_EN: bus_rdata = DW'(r_q.wake_en);
            A_CTRL:    bus_rdata = DW'(r_q.ctrl);
            A_COUNT:   bus_rdata = count;
            A_RELOAD:  bus_rdata = r_q.load;
            A_FIRE:    bus_rdata = '1;
            A_PEND:    bus_rdata = '0;
            A_MATCH:   bus_rdata = r_q.match;
            A_SYNC:    bus_rdata = DW'({r_q.posted, 2'b00});
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl      = r_q.ctrl;
    assign load_val  = r_q.load;
    assign match_val = r_q.match;
    assign irq       = |r_q.status;
    assign wake      = r_q.wake;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PTV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              wake,
    output logic              tmr_out
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count, load_val, match_val;
    logic             tick, ovf_evt, mat_evt, stop_req;
    logic             cnt_wr, fire, ctrl_wr, sreset;

    evt_timer_regs #(.DW(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .ovf_evt   (ovf_evt),
        .mat_evt   (mat_evt),
        .stop_req  (stop_req),
        .ctrl      (ctrl),
        .load_val  (load_val),
        .match_val (match_val),
        .irq       (irq),
        .wake      (wake),
        .sreset    (sreset),
        .cnt_wr    (cnt_wr),
        .fire      (fire),
        .ctrl_wr   (ctrl_wr)
    );

    evt_timer_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl_wr || sreset),
        .run    (ctrl.start),
        .pre_en (ctrl.pre_en),
        .ptv    (ctrl.ptv),
        .tick   (tick)
    );

    evt_timer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sreset),
        .tick      (tick),
        .auto_rl   (ctrl.auto_rl),
        .cmp_en    (ctrl.cmp_en),
        .load_val  (load_val),
        .match_val (match_val),
        .set_wr    (cnt_wr),
        .set_val   (bus_wdata),
        .fire      (fire),
        .count     (count),
        .ovf_evt   (ovf_evt),
        .mat_evt   (mat_evt),
        .stop_req  (stop_req)
    );

    evt_timer_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sreset),
        .trig    (ctrl.trig),
        .toggle  (ctrl.toggle),
        .dflt    (ctrl.dflt),
        .pin_in  (ctrl.pin_in),
        .ovf_evt (ovf_evt),
        .mat_evt (mat_evt),
        .pin     (tmr_out)
    );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             start,
    input logic             auto_rl,
    input logic             pin_in,
    input logic             dflt,
    input logic             trig_none,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val,
    input logic             ovf_evt,
    input logic             mat_evt,
    input logic             cnt_wr,
    input logic             fire,
    input logic             ctrl_wr,
    input logic             sreset,
    input logic             irq,
    input logic             wake,
    input logic             pin_out
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(&count) && !cnt_wr && !fire && !sreset) |=> (count == $past(count) + CNT_W'(1)));

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !cnt_wr && !fire && !sreset) |=> $stable(count));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count) && auto_rl && !cnt_wr && !fire && !sreset)
        |=> (count == $past(load_val) && ovf_evt));

    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count) && !auto_rl && !cnt_wr && !fire && !ctrl_wr && !sreset)
        |=> (count == '0 && !start));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ovf_evt || mat_evt));

    p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(ovf_evt || mat_evt));

    p_default_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_none && !pin_in && !sreset) |=> (pin_out == $past(dflt)));

    p_pin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_in && !sreset) |=> $stable(pin_out));

    p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (count == '0 && !irq && !start && !pin_out));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (ctrl.start),
    .auto_rl   (ctrl.auto_rl),
    .pin_in    (ctrl.pin_in),
    .dflt      (ctrl.dflt),
    .trig_none (ctrl.trig == evt_timer_pkg::TRG_NONE),
    .count     (count),
    .load_val  (load_val),
    .ovf_evt   (ovf_evt),
    .mat_evt   (mat_evt),
    .cnt_wr    (cnt_wr),
    .fire      (fire),
    .ctrl_wr   (ctrl_wr),
    .sreset    (sreset),
    .irq       (irq),
    .wake      (wake),
    .pin_out   (tmr_out)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake, tmr_out;
    int          checks = 0;
    int          errors = 0;

    localparam logic [3:0] AD_ID = 0, AD_SYSCFG = 1, AD_STATUS = 2, AD_IE = 3,
                           AD_WE = 4, AD_CTRL = 5, AD_COUNT = 6, AD_RELOAD = 7,
                           AD_FIRE = 8, AD_PEND = 9, AD_MATCH = 10, AD_SYNC = 11;

    always #2 clk = ~clk;

    evt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake), .tmr_out(tmr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 wake", {31'b0, wake}, 0);
        check("R1 pin", {31'b0, tmr_out}, 0);
        chk_reg("R1 count", AD_COUNT, 0);
        chk_reg("R1 id", AD_ID, 32'h21);
        chk_reg("R1 fire", AD_FIRE, 32'hFFFF_FFFF);
        chk_reg("R1 pend", AD_PEND, 0);
        chk_reg("R1 sync", AD_SYNC, 4);

        // R14 readback
        wr(AD_CTRL, 32'h7FFE);
        chk_reg("R14 ctrl", AD_CTRL, 32'h7FFE);
        wr(AD_SYSCFG, 32'h3FD);
        chk_reg("R14 syscfg", AD_SYSCFG, 32'h33D);
        wr(AD_CTRL, 0);

        // R2 free counting and hold
        wr(AD_COUNT, 100);
        wr(AD_CTRL, 1);
        edges(5);
        chk_reg("R2 count", AD_COUNT, 105);
        wr(AD_CTRL, 0);
        begin
            logic [31:0] held;
            bus_addr = AD_COUNT; #1; held = bus_rdata;
            edges(4);
            chk_reg("R2 hold", AD_COUNT, held);
        end

        // R3 prescaler sweep
        for (int pre = 0; pre < 2; pre++) begin
            for (int p = 0; p < 8; p++) begin
                int n;
                n = (pre != 0) ? (1 << (p + 1)) : 1;
                wr(AD_CTRL, 0);
                wr(AD_COUNT, 0);
                wr(AD_CTRL, 32'(1 | (pre << 5) | (p << 2)));
                edges(2 * n - 1);
                chk_reg("R3 first", AD_COUNT, 32'((2 * n - 1) / n));
                edges(n + 1);
                chk_reg("R3 later", AD_COUNT, 32'((3 * n) / n));
            end
        end

        // R4 overflow with reload, R7 interrupt timing
        wr(AD_CTRL, 0);
        wr(AD_WE, 0);
        wr(AD_RELOAD, 32'h100);
        wr(AD_COUNT, 32'hFFFF_FFFD);
        wr(AD_IE, 2);
        wr(AD_CTRL, 3);
        edges(3);
        chk_reg("R4 reload", AD_COUNT, 32'h100);
        check("R7 irq not yet", {31'b0, irq}, 0);
        edges(1);
        check("R7 irq set", {31'b0, irq}, 1);
        chk_reg("R4 continues", AD_COUNT, 32'h101);
        chk_reg("R4 start kept", AD_CTRL, 3);
        chk_reg("R7 status", AD_STATUS, 2);
        wr(AD_STATUS, 2);
        check("R7 irq cleared", {31'b0, irq}, 0);
        chk_reg("R7 status cleared", AD_STATUS, 0);

        // R5 overflow without reload, R8 wakeup without interrupt
        wr(AD_CTRL, 0);
        wr(AD_IE, 0);
        wr(AD_WE, 2);
        wr(AD_COUNT, 32'hFFFF_FFFE);
        wr(AD_CTRL, 1);
        edges(2);
        chk_reg("R5 zero", AD_COUNT, 0);
        chk_reg("R5 start clear", AD_CTRL, 0);
        edges(1);
        check("R8 wake pulse", {31'b0, wake}, 1);
        check("R7 masked irq", {31'b0, irq}, 0);
        chk_reg("R7 masked status", AD_STATUS, 0);
        edges(1);
        check("R8 wake one cycle", {31'b0, wake}, 0);
        chk_reg("R5 stopped", AD_COUNT, 0);

        // R6 match
        wr(AD_WE, 0);
        wr(AD_COUNT, 10);
        wr(AD_MATCH, 14);
        wr(AD_IE, 1);
        wr(AD_CTRL, 32'h41);
        edges(4);
        chk_reg("R6 not yet", AD_STATUS, 0);
        edges(1);
        chk_reg("R6 match status", AD_STATUS, 1);
        check("R6 irq", {31'b0, irq}, 1);
        wr(AD_STATUS, 1);
        check("R7 clear match", {31'b0, irq}, 0);
        wr(AD_CTRL, 0);
        wr(AD_COUNT, 10);
        wr(AD_CTRL, 1);
        edges(8);
        chk_reg("R6 disabled", AD_STATUS, 0);

        // R12 count write and fire
        wr(AD_CTRL, 0);
        wr(AD_RELOAD, 32'h55);
        wr(AD_COUNT, 7);
        chk_reg("R12 set", AD_COUNT, 7);
        wr(AD_FIRE, 32'h1234);
        chk_reg("R12 fire", AD_COUNT, 32'h55);

        // R9 R10 R11 pin sweep: overflow every 4th step, match one step after reload
        for (int dir = 0; dir < 2; dir++)
        for (int trg = 0; trg < 4; trg++)
        for (int tog = 0; tog < 2; tog++)
        for (int dl = 0; dl < 2; dl++) begin
            logic exp_pin;
            string tag;
            tag = (dir != 0) ? "R11" : ((trg == 0) ? "R9" : "R10");
            wr(AD_CTRL, 32'(dl << 7));
            wr(AD_COUNT, 32'hFFFF_FFFC);
            wr(AD_RELOAD, 32'hFFFF_FFFC);
            wr(AD_MATCH, 32'hFFFF_FFFD);
            wr(AD_CTRL, 32'(1 | 2 | (1 << 6) | (dl << 7) | (trg << 10) | (tog << 12) | (dir << 14)));
            exp_pin = dl[0];
            for (int j = 1; j <= 10; j++) begin
                logic ov, mt, hit;
                edges(1);
                ov  = (j - 1 > 0) && ((j - 1) % 4 == 0);
                mt  = ((j - 1) % 4 == 1);
                hit = (((trg == 1) || (trg == 2)) && ov) || ((trg == 2) && mt);
                if (dir == 0) begin
                    if (trg == 0)      exp_pin = dl[0];
                    else if (tog != 0) exp_pin = hit ? ~exp_pin : exp_pin;
                    else               exp_pin = dl[0] ^ hit;
                end
                check(tag, {31'b0, tmr_out}, {31'b0, exp_pin});
            end
        end

        // R13 soft reset
        wr(AD_CTRL, 32'h83);
        wr(AD_IE, 7);
        wr(AD_RELOAD, 9);
        wr(AD_SYNC, 0);
        check("R9 default high", {31'b0, tmr_out}, 1);
        chk_reg("R13 posted cleared", AD_SYNC, 0);
        wr(AD_SYSCFG, 2);
        check("R13 pin", {31'b0, tmr_out}, 0);
        chk_reg("R13 count", AD_COUNT, 0);
        chk_reg("R13 ctrl", AD_CTRL, 0);
        chk_reg("R13 reload", AD_RELOAD, 0);
        chk_reg("R13 ie", AD_IE, 0);
        chk_reg("R13 sync", AD_SYNC, 4);
        chk_reg("R13 syscfg", AD_SYSCFG, 0);
        wr(AD_RELOAD, 5);
        wr(AD_SYNC, 2);
        chk_reg("R13 via sync", AD_RELOAD, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule